// File: doc/BRIEF.md
# E1 Transmit Line Encoder

This block is one transmit channel of an E1 line interface. It takes NRZ data timed by the 2.048 MHz transmit clock. It turns that data into two pulse indications, one for a positive and one for a negative line pulse, which go to the line driver. Inputs are sampled on the falling edge of the transmit clock, and both outputs are registered on that same edge.

A two-bit mode select chooses among three input modes. The two single-rail modes code the data input with AMI, or with HDB3 when the coding select is set. In the second single-rail mode, the negative input is not a data rail. It becomes a test request: a rising edge on it makes the next mark break the alternation rule. Dual-rail mode takes pre-coded positive and negative data and passes it through to the outputs. While dual-rail mode is selected, a negative input that stays high for longer than a set number of samples moves the channel into the first single-rail mode. The channel stays there until the mode select leaves dual-rail.

Top module: `e1tx_encoder`

## Requirements
- R1: A synchronous active-low reset clears both pulse outputs on the first falling clock edge at which reset is sampled low.
- R2: The positive and negative pulse outputs are never high at the same time.
- R3: Dual-rail mode is selected when mode_sel[1] is 1. In this mode each sample maps to the output registered on the same edge: P=1,N=0 gives a positive pulse, P=0,N=1 gives a negative pulse, and the other two combinations give no pulse.
- R4: In single-rail AMI mode (mode_sel[1]=0, hdb3_en=0), a data one gives a pulse and a zero gives none, registered on the sampling edge. Successive pulses alternate in polarity, and the first pulse after reset is positive.
- R5: With HDB3 selected, the output for a sample appears four clock edges later than it would with AMI. Ordinary ones still alternate in polarity.
- R6: HDB3 replaces every run of four zeros. The replacement is 000V when the number of pulses since the previous V is odd, and also for the first run after reset. Otherwise the replacement is B00V. A B pulse takes the polarity opposite to the previous pulse, and a V pulse repeats the polarity of the previous pulse.
- R7: In mode_sel=01 with AMI, a 0-to-1 transition on din_n arms a violation. The next data one is sent with the same polarity as the previous pulse. The one after it is opposite to the violating pulse.
- R8: A further 0-to-1 transition on din_n while a violation is still armed is ignored, so only one mark breaks alternation.
- R9: Transitions on din_n cause no violation in mode_sel=00, or in mode_sel=01 with HDB3 selected.
- R10: In dual-rail mode, a din_n that is high for more than RUN_LIMIT (16) consecutive samples switches the channel to single-rail mode 00 behaviour from the next sample on. A run of exactly 16 samples does not switch it.
- R11: The forced single-rail state clears when mode_sel[1] is sampled 0, so a later return to dual-rail mode gives pass-through behaviour again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tx_clk | input | 1 | Transmit clock; the falling edge samples inputs and updates state |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | 00 single-rail, 01 single-rail with violation request, 1x dual-rail |
| hdb3_en | input | 1 | 1 selects HDB3 coding in the single-rail modes, 0 selects AMI |
| din_p | input | 1 | NRZ data (single-rail) or positive rail (dual-rail) |
| din_n | input | 1 | Negative rail (dual-rail) or violation request (mode 01) |
| pulse_pos | output | 1 | Registered positive-pulse indication |
| pulse_neg | output | 1 | Registered negative-pulse indication |

## Verification
The hardest conditions to reach from the ports lie at the edges of the rail-mode detector and of the violation request. Holding din_n high for exactly sixteen samples must leave dual-rail mode in place, and seventeen must leave it. The stimulus therefore drives both run lengths from reset and then probes with P=1,N=1, which gives a space in dual-rail mode and a mark in single-rail mode. A second violation request is timed to land on the very sample that carries the violating mark. Each HDB3 pattern starts from reset, so the first replacement and the odd/even pulse-count rule can each be isolated.

// File: rtl/e1tx_pkg.sv
// Shared types and constants for the E1 transmit line encoder.
package e1tx_pkg;

    // Symbol classes handed from the coding stage to the polarity stage.
    typedef enum logic [1:0] {
        SYM_SPACE  = 2'd0,
        SYM_MARK   = 2'd1,
        SYM_BPULSE = 2'd2,
        SYM_VPULSE = 2'd3
    } e1tx_sym_t;

    // Length of the zero run that HDB3 replaces.
    localparam int HDB3_ZRUN = 4;

    // Mode-select codes for the two single-rail modes; bit 1 set means dual-rail.
    localparam logic [1:0] MODE_SR_PLAIN = 2'b00;
    localparam logic [1:0] MODE_SR_VIOL  = 2'b01;

endpackage

// File: rtl/e1tx_rail_detect.sv
// Dual-rail to single-rail detector.
// Counts consecutive high samples of the negative rail while dual-rail
// mode is configured. On the sample after RUN_LIMIT highs it sets
// force_single, which holds until dual-rail is deselected or reset.
// Assumes: everything is sampled on the falling edge of clk.
module e1tx_rail_detect #(
    parameter int RUN_LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dual_cfg,
    input  logic neg_in,
    output logic force_single
);
    localparam int CW = $clog2(RUN_LIMIT + 1);

    logic [CW-1:0] run_q;

    // Run counter and sticky switch-over flag.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            run_q        <= '0;
            force_single <= 1'b0;
        end else if (!dual_cfg) begin
            run_q        <= '0;
            force_single <= 1'b0;
        end else if (!force_single) begin
            if (neg_in) begin
                if (run_q == CW'(RUN_LIMIT)) begin
                    force_single <= 1'b1;
                end else begin
                    run_q <= run_q + 1'b1;
                end
            end else begin
                run_q <= '0;
            end
        end
    end

endmodule

// File: rtl/e1tx_hdb3_window.sv
// HDB3 lookahead window.
// Delays the data stream by ZRUN samples. When the newest sample, together
// with the ZRUN-1 samples ahead of it, makes a run of plain zeros, the run
// is tagged as 000V or B00V. The choice follows the parity of the pulses
// since the last V; the first replacement after reset is always 000V.
// Assumes: ZRUN is 4 for standard HDB3; the stage at index 0 leaves first.
module e1tx_hdb3_window
    import e1tx_pkg::*;
#(
    parameter int ZRUN = HDB3_ZRUN
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      bit_in,
    output e1tx_sym_t sym_out
);
    localparam int FW = (ZRUN > 2) ? $clog2(ZRUN) : 1;

    e1tx_sym_t     stage_q   [ZRUN];
    e1tx_sym_t     stage_nxt [ZRUN];
    logic [FW-1:0] fill_q;
    logic          first_q;
    logic          odd_q;
    logic          zrun_hit;
    logic          use_bv;

    // Detect a zero run across the window and build the shifted contents.
    always_comb begin
        zrun_hit = !bit_in && (fill_q == FW'(ZRUN - 1));
        for (int i = 1; i < ZRUN; i++) begin
            if (stage_q[i] != SYM_SPACE) zrun_hit = 1'b0;
        end
        use_bv = zrun_hit && !first_q && !odd_q;
        for (int i = 0; i < ZRUN - 1; i++) begin
            stage_nxt[i] = stage_q[i + 1];
        end
        stage_nxt[ZRUN-1] = bit_in ? SYM_MARK : SYM_SPACE;
        if (zrun_hit) stage_nxt[ZRUN-1] = SYM_VPULSE;
        if (use_bv)   stage_nxt[0]      = SYM_BPULSE;
    end

    // Shift the window and track fill level and pulse parity.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ZRUN; i++) stage_q[i] <= SYM_SPACE;
            fill_q  <= '0;
            first_q <= 1'b1;
            odd_q   <= 1'b0;
        end else begin
            for (int i = 0; i < ZRUN; i++) stage_q[i] <= stage_nxt[i];
            if (fill_q != FW'(ZRUN - 1)) fill_q <= fill_q + 1'b1;
            if (zrun_hit) begin
                first_q <= 1'b0;
                odd_q   <= 1'b0;
            end else if (bit_in) begin
                odd_q <= ~odd_q;
            end
        end
    end

    assign sym_out = stage_q[0];

endmodule

// File: rtl/e1tx_viol_arm.sv
// Violation request capture.
// A 0-to-1 change on req_in while enable is high arms a pending flag.
// The flag clears when the polarity stage reports that the violating mark
// has gone out. A request that arrives while the flag is armed is dropped.
// Assumes: the previous-level register resets high, so a level already
// high when reset is released is not taken as an edge.
module e1tx_viol_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic req_in,
    input  logic consume,
    output logic pending
);
    logic prev_q;
    logic rise;

    assign rise = req_in && !prev_q;

    // Edge history of the request input.
    always_ff @(negedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= req_in;
    end

    // Pending flag: arm on an edge, clear once consumed.
    always_ff @(negedge clk) begin
        if (!rst_n || !enable) begin
            pending <= 1'b0;
        end else if (pending) begin
            if (consume) pending <= 1'b0;
        end else if (rise) begin
            pending <= 1'b1;
        end
    end

endmodule

// File: rtl/e1tx_line_polarity.sv
// Polarity stage and output registers.
// In single-rail operation it turns symbols into alternating pulses: a mark
// or B pulse takes the polarity opposite to the last one and toggles the
// state, while a V pulse, or a mark with force_same set, repeats the last
// polarity. In dual-rail operation it registers the rails directly.
// Assumes: polarity state resets to negative, so the first mark is positive.
module e1tx_line_polarity
    import e1tx_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      dual_sel,
    input  logic      dual_p,
    input  logic      dual_n,
    input  e1tx_sym_t sym_in,
    input  logic      force_same,
    output logic      consume,
    output logic      pulse_pos,
    output logic      pulse_neg
);
    logic last_pos_q;
    logic emit;
    logic emit_pos;
    logic flip;

    // Decide pulse presence, polarity and state update for this symbol.
    always_comb begin
        emit     = 1'b0;
        emit_pos = 1'b0;
        flip     = 1'b0;
        consume  = 1'b0;
        unique case (sym_in)
            SYM_MARK: begin
                emit = 1'b1;
                if (force_same) begin
                    emit_pos = last_pos_q;
                    consume  = !dual_sel;
                end else begin
                    emit_pos = !last_pos_q;
                    flip     = 1'b1;
                end
            end
            SYM_BPULSE: begin
                emit     = 1'b1;
                emit_pos = !last_pos_q;
                flip     = 1'b1;
            end
            SYM_VPULSE: begin
                emit     = 1'b1;
                emit_pos = last_pos_q;
            end
            default: ;
        endcase
    end

    // Register the line outputs and the polarity state.
    always_ff @(negedge clk) begin
        if (!rst_n) begin
            pulse_pos  <= 1'b0;
            pulse_neg  <= 1'b0;
            last_pos_q <= 1'b0;
        end else if (dual_sel) begin
            pulse_pos <= dual_p && !dual_n;
            pulse_neg <= dual_n && !dual_p;
        end else begin
            pulse_pos <= emit && emit_pos;
            pulse_neg <= emit && !emit_pos;
            if (flip) last_pos_q <= !last_pos_q;
        end
    end

endmodule

// File: rtl/e1tx_encoder.sv
// E1 transmit line encoder, top level.
// Selects the input mode, optionally forces dual-rail over to single-rail,
// routes data through AMI directly or through the HDB3 window, and drives
// the registered positive and negative pulse indications.
// Assumes: inputs are stable around the falling edge of tx_clk.
module e1tx_encoder
    import e1tx_pkg::*;
#(
    parameter int RUN_LIMIT = 16,
    parameter int ZRUN      = HDB3_ZRUN
) (
    input  logic       tx_clk,
    input  logic       rst_n,
    input  logic [1:0] mode_sel,
    input  logic       hdb3_en,
    input  logic       din_p,
    input  logic       din_n,
    output logic       pulse_pos,
    output logic       pulse_neg
);
    logic      force_single;
    logic      dual_eff;
    logic      viol_en;
    logic      viol_pending;
    logic      viol_consume;
    e1tx_sym_t win_sym;
    e1tx_sym_t sym_sel;

    assign dual_eff = mode_sel[1] && !force_single;
    assign viol_en  = (mode_sel == MODE_SR_VIOL) && !hdb3_en;

    // Symbol source: the lookahead window for HDB3, raw data for AMI.
    always_comb begin
        if (hdb3_en) sym_sel = win_sym;
        else         sym_sel = din_p ? SYM_MARK : SYM_SPACE;
    end

    e1tx_rail_detect #(.RUN_LIMIT(RUN_LIMIT)) u_detect (
        .clk          (tx_clk),
        .rst_n        (rst_n),
        .dual_cfg     (mode_sel[1]),
        .neg_in       (din_n),
        .force_single (force_single)
    );

    e1tx_hdb3_window #(.ZRUN(ZRUN)) u_window (
        .clk     (tx_clk),
        .rst_n   (rst_n),
        .bit_in  (din_p),
        .sym_out (win_sym)
    );

    e1tx_viol_arm u_viol (
        .clk     (tx_clk),
        .rst_n   (rst_n),
        .enable  (viol_en),
        .req_in  (din_n),
        .consume (viol_consume),
        .pending (viol_pending)
    );

    e1tx_line_polarity u_pol (
        .clk        (tx_clk),
        .rst_n      (rst_n),
        .dual_sel   (dual_eff),
        .dual_p     (din_p),
        .dual_n     (din_n),
        .sym_in     (sym_sel),
        .force_same (viol_pending),
        .consume    (viol_consume),
        .pulse_pos  (pulse_pos),
        .pulse_neg  (pulse_neg)
    );

endmodule

// File: rtl/e1tx_encoder_chk.sv
// Property checker for e1tx_encoder, attached by bind below.
// Keeps its own record of pulse polarity and of din_n run length, built
// from the ports, and relates them to the outputs.
module e1tx_encoder_chk #(
    parameter int RUN_LIMIT = 16
) (
    input logic       tx_clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       hdb3_en,
    input logic       din_p,
    input logic       din_n,
    input logic       pulse_pos,
    input logic       pulse_neg,
    input logic       force_single
);
    localparam int CW = $clog2(RUN_LIMIT + 2);

    logic          seen_pos_q;
    logic [CW-1:0] run_q;

    // Polarity of the last single-rail pulse seen at the outputs.
    always_ff @(negedge tx_clk) begin
        if (!rst_n) seen_pos_q <= 1'b0;
        else if ((pulse_pos || pulse_neg) && !$past(mode_sel[1])) seen_pos_q <= pulse_pos;
    end

    // Independent count of consecutive din_n highs in dual-rail config.
    always_ff @(negedge tx_clk) begin
        if (!rst_n || !mode_sel[1] || !din_n) run_q <= '0;
        else if (run_q != CW'(RUN_LIMIT + 1)) run_q <= run_q + 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(negedge tx_clk)
        !rst_n |=> (!pulse_pos && !pulse_neg));

    // R2
    no_dual_pulse_chk: assert property (@(negedge tx_clk) disable iff (!rst_n)
        !(pulse_pos && pulse_neg));

    // R3
    dual_pass_chk: assert property (@(negedge tx_clk) disable iff (!rst_n)
        (mode_sel[1] && !force_single && din_p && !din_n) |=> (pulse_pos && !pulse_neg));

    // R4
    ami_alternate_chk: assert property (@(negedge tx_clk) disable iff (!rst_n)
        ((pulse_pos || pulse_neg) && $past(mode_sel == 2'b00 && !hdb3_en))
        |-> (pulse_pos != seen_pos_q));

    // R10
    rail_switch_chk: assert property (@(negedge tx_clk) disable iff (!rst_n)
        $rose(force_single) |-> (run_q > CW'(RUN_LIMIT)));

endmodule

bind e1tx_encoder e1tx_encoder_chk #(.RUN_LIMIT(RUN_LIMIT)) u_chk (
    .tx_clk       (tx_clk),
    .rst_n        (rst_n),
    .mode_sel     (mode_sel),
    .hdb3_en      (hdb3_en),
    .din_p        (din_p),
    .din_n        (din_n),
    .pulse_pos    (pulse_pos),
    .pulse_neg    (pulse_neg),
    .force_single (force_single)
);

// File: tb/sim_e1tx_encoder.sv
module sim_e1tx_encoder;
    localparam int CLK_PERIOD = 10;

    logic       tx_clk   = 1'b0;
    logic       rst_n    = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       hdb3_en  = 1'b0;
    logic       din_p    = 1'b0;
    logic       din_n    = 1'b0;
    logic       pulse_pos;
    logic       pulse_neg;

    int n_chk = 0;
    int n_bad = 0;
    int cap [64];

    e1tx_encoder u0 (
        .tx_clk    (tx_clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .hdb3_en   (hdb3_en),
        .din_p     (din_p),
        .din_n     (din_n),
        .pulse_pos (pulse_pos),
        .pulse_neg (pulse_neg)
    );

    always #(CLK_PERIOD/2) tx_clk = ~tx_clk;

    // +1 positive, -1 negative, 0 space, 9 both (illegal)
    function automatic int lvl();
        if (pulse_pos && pulse_neg) return 9;
        if (pulse_pos) return 1;
        if (pulse_neg) return -1;
        return 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(posedge tx_clk);
        rst_n = 1'b0; din_p = 1'b0; din_n = 1'b0;
        repeat (3) @(posedge tx_clk);
        rst_n = 1'b1;
    endtask

    // Bit j of pv/nv is driven for sample j; cap[j] is the output after sample j.
    task automatic drive_seq(input int len, input logic [63:0] pv, input logic [63:0] nv);
        for (int j = 0; j < len; j++) begin
            @(posedge tx_clk);
            if (j > 0) begin
                cap[j-1] = lvl();
                chk("R2 exclusive pulses", (cap[j-1] == 9) ? 1 : 0, 0);
            end
            din_p = pv[j];
            din_n = nv[j];
        end
        @(posedge tx_clk);
        cap[len-1] = lvl();
        chk("R2 exclusive pulses", (cap[len-1] == 9) ? 1 : 0, 0);
        din_p = 1'b0;
        din_n = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        mode_sel = 2'b10; hdb3_en = 1'b0;
        @(posedge tx_clk);
        chk("R1 idle after reset", lvl(), 0);
        drive_seq(2, 64'h3, 64'h0);
        chk("R3 positive before reset", cap[1], 1);
        rst_n = 1'b0; din_p = 1'b1;
        @(posedge tx_clk);
        chk("R1 cleared by reset", lvl(), 0);
        rst_n = 1'b1; din_p = 1'b0;
    endtask

    task automatic t_dual_map();
        int exp [6] = '{1, -1, 0, 0, 1, 1};
        do_reset();
        mode_sel = 2'b10; hdb3_en = 1'b0;
        drive_seq(6, 64'h35, 64'h06);
        for (int j = 0; j < 6; j++) chk("R3 dual map", cap[j], exp[j]);
    endtask

    task automatic t_ami_plain();
        int exp [8] = '{1, -1, 0, 1, 0, 0, -1, 1};
        do_reset();
        mode_sel = 2'b00; hdb3_en = 1'b0;
        drive_seq(8, 64'hCB, 64'hAA);
        for (int j = 0; j < 8; j++) chk("R4 R9 ami, din_n ignored", cap[j], exp[j]);
    endtask

    task automatic t_hdb3_first_even();
        int exp [11] = '{1, 0, 0, 0, 1, -1, 1, -1, 0, 0, -1};
        do_reset();
        mode_sel = 2'b00; hdb3_en = 1'b1;
        drive_seq(15, 64'h61, 64'h0);
        for (int j = 0; j < 11; j++) chk("R5 R6 hdb3 000V then B00V", cap[j+4], exp[j]);
        for (int j = 0; j < 4; j++) chk("R5 hdb3 delay", cap[j], 0);
    endtask

    task automatic t_hdb3_odd();
        int exp [10] = '{1, 0, 0, 0, 1, -1, 0, 0, 0, -1};
        do_reset();
        mode_sel = 2'b00; hdb3_en = 1'b1;
        drive_seq(14, 64'h21, 64'h0);
        for (int j = 0; j < 10; j++) chk("R6 hdb3 odd count 000V", cap[j+4], exp[j]);
    endtask

    task automatic t_violation();
        int exp [9] = '{1, 0, 0, 1, -1, 1, 0, 1, -1};
        do_reset();
        mode_sel = 2'b01; hdb3_en = 1'b0;
        drive_seq(9, 64'h1B9, 64'h5A);
        for (int j = 0; j < 9; j++) chk("R7 R8 violation insert", cap[j], exp[j]);
    endtask

    task automatic t_violation_hdb3();
        int exp [3] = '{1, -1, 1};
        do_reset();
        mode_sel = 2'b01; hdb3_en = 1'b1;
        drive_seq(8, 64'hFE, 64'h55);
        for (int j = 0; j < 3; j++) chk("R9 no violation under hdb3", cap[j+5], exp[j]);
    endtask

    task automatic t_detect_sixteen();
        do_reset();
        mode_sel = 2'b10; hdb3_en = 1'b0;
        drive_seq(19, 64'h60000, 64'h2FFFF);
        chk("R10 dual during run of 16", cap[15], -1);
        chk("R10 dual after gap", cap[16], 0);
        chk("R10 still dual, 11 is space", cap[17], 0);
        chk("R10 still dual, 10 positive", cap[18], 1);
    endtask

    task automatic t_detect_seventeen();
        do_reset();
        mode_sel = 2'b10; hdb3_en = 1'b0;
        drive_seq(20, 64'h60000, 64'hBFFFF);
        chk("R10 last dual sample", cap[16], -1);
        chk("R10 switched, first mark", cap[17], 1);
        chk("R10 switched, alternates", cap[18], -1);
        chk("R10 switched, din_n ignored", cap[19], 0);
        mode_sel = 2'b00;
        drive_seq(1, 64'h0, 64'h0);
        mode_sel = 2'b10;
        drive_seq(2, 64'h1, 64'h3);
        chk("R11 dual restored, 11 space", cap[0], 0);
        chk("R11 dual restored, 01 negative", cap[1], -1);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset_state();
        t_dual_map();
        t_ami_plain();
        t_hdb3_first_even();
        t_hdb3_odd();
        t_violation();
        t_violation_hdb3();
        t_detect_sixteen();
        t_detect_seventeen();
        repeat (2) @(posedge tx_clk);
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule